// File: doc/BRIEF.md
# Addressed Serial Configuration Loader

This block is a three-wire programming port for a larger chip. A host shifts a 21-bit word in over a serial clock and a serial data line, most significant bit first. Raising the load-enable line then copies that word into one of four parallel configuration registers. The two least significant bits of the word pick the register and are not kept. The other 19 bits become the register's new contents. Each register has a strobe that pulses for one system clock cycle when it takes a new value.

The three serial pins are asynchronous to the system clock. Each one passes through a synchronizer before its edges are detected. A serial data-out line shows the most significant bit of the shift register and changes only after a falling serial clock edge, so a host can read the register back as it shifts in a new word. While load-enable is high, rising serial clock edges are ignored, so the word being transferred cannot change.

Top module: `sps_prog_port`

## Requirements
- R1: While reset is asserted and right after it, all four configuration registers are zero, all update strobes are low, and the data-out line is low.
- R2: The shift register is 21 bits wide and takes the data bit on each rising serial clock edge. The first bit shifted in ends up in bit 20 of the word.
- R3: Bits [1:0] of the word select the destination register: value 0 selects register 0, 1 selects register 1, 2 selects register 2 and 3 selects register 3. The registers not selected keep their values.
- R4: The selected register receives word bits [20:2] as its bits [18:0]. The two select bits are not stored.
- R5: Each rising edge of load-enable pulses the strobe of the selected register for exactly one system clock cycle. At most one strobe is high at any time, and no strobe pulses on other cycles.
- R6: Rising serial clock edges that occur while load-enable is high do not change the shift register. A later load delivers the same word again.
- R7: After each falling serial clock edge, data-out shows bit 20 of the shift register. It does not change at any other time.
- R8: Shifting in a word without raising load-enable leaves all configuration registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| ser_le_i | input | 1 | Load enable; a rising edge transfers the word |
| ser_dout_o | output | 1 | Readback of the shift register's top bit |
| cfg_o | output | 4x19 | Contents of the four configuration registers |
| cfg_upd_o | output | 4 | One-cycle update strobe for each register |

## Verification
A wrong internal state shows up at the ports within one serial bit time or one load. A shift register that drops, repeats or reverses bits changes data-out at the next falling serial edge. It also puts a wrong payload into the register named by the select bits. A shift that is not frozen while load-enable is high makes the repeated load deliver a different word. A wrong select decode shows up as a strobe and a value change on a register that should have kept its contents.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int unsigned SPS_WORD_W  = 21;
  localparam int unsigned SPS_SEL_W   = 2;
  localparam int unsigned SPS_SYNC    = 2;
  localparam int unsigned PIN_SCLK    = 0;
  localparam int unsigned PIN_SDAT    = 1;
  localparam int unsigned PIN_LE      = 2;
  localparam int unsigned PIN_COUNT   = 3;
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = pin_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/sps_shift.sv
module sps_shift #(
  parameter int unsigned WORD_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en_i,
  input  logic              bit_i,
  input  logic              out_en_i,
  output logic [WORD_W-1:0] sreg_o,
  output logic              dout_o
);
  logic [WORD_W-1:0] sreg_q;
  logic [WORD_W-1:0] sreg_d;
  logic              dout_q;
  logic              dout_d;

  always_comb begin
    sreg_d = {sreg_q[WORD_W-2:0], bit_i};
    dout_d = sreg_q[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else if (shift_en_i) begin
      sreg_q <= sreg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= 1'b0;
    end else if (out_en_i) begin
      dout_q <= dout_d;
    end
  end

  assign sreg_o = sreg_q;
  assign dout_o = dout_q;
endmodule

// File: rtl/sps_latch_bank.sv
module sps_latch_bank #(
  parameter int unsigned WORD_W = 21,
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned PAY_W     = WORD_W - SEL_W,
  localparam int unsigned NUM_LATCH = 1 << SEL_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load_i,
  input  logic [WORD_W-1:0]                word_i,
  output logic [NUM_LATCH-1:0][PAY_W-1:0]  cfg_o,
  output logic [NUM_LATCH-1:0]             upd_o
);
  logic [SEL_W-1:0] sel;
  logic [PAY_W-1:0] payload;
  logic [NUM_LATCH-1:0] upd_d;
  logic [NUM_LATCH-1:0] upd_q;

  assign sel     = word_i[SEL_W-1:0];
  assign payload = word_i[WORD_W-1:SEL_W];

  generate
    for (genvar k = 0; k < NUM_LATCH; k++) begin : g_latch
      logic [PAY_W-1:0] cfg_q;

      always_comb upd_d[k] = load_i && (sel == SEL_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q <= '0;
        end else if (upd_d[k]) begin
          cfg_q <= payload;
        end
      end

      assign cfg_o[k] = cfg_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= '0;
    else        upd_q <= upd_d;
  end

  assign upd_o = upd_q;
endmodule

// File: rtl/sps_prog_port.sv
module sps_prog_port
  import sps_pkg::*;
#(
  parameter int unsigned WORD_W      = SPS_WORD_W,
  parameter int unsigned SEL_W       = SPS_SEL_W,
  parameter int unsigned SYNC_STAGES = SPS_SYNC,
  localparam int unsigned PAY_W      = WORD_W - SEL_W,
  localparam int unsigned NUM_LATCH  = 1 << SEL_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ser_clk_i,
  input  logic                            ser_dat_i,
  input  logic                            ser_le_i,
  output logic                            ser_dout_o,
  output logic [NUM_LATCH-1:0][PAY_W-1:0] cfg_o,
  output logic [NUM_LATCH-1:0]            cfg_upd_o
);
  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Pin synchronizers
  logic [PIN_COUNT-1:0] pin_raw;
  logic [PIN_COUNT-1:0] pin_lvl;

  assign pin_raw[PIN_SCLK] = ser_clk_i;
  assign pin_raw[PIN_SDAT] = ser_dat_i;
  assign pin_raw[PIN_LE]   = ser_le_i;

  generate
    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
      sps_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .pin_i (pin_raw[p]),
        .lvl_o (pin_lvl[p])
      );
    end
  endgenerate

  // Edge detection on serial clock and load enable
  logic sclk_prev_q, sclk_prev_d;
  logic le_prev_q, le_prev_d;
  logic sclk_rise, sclk_fall, le_lvl, le_rise, shift_en;

  always_comb begin
    sclk_prev_d = pin_lvl[PIN_SCLK];
    le_prev_d   = pin_lvl[PIN_LE];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sclk_prev_q <= 1'b0;
      le_prev_q   <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_prev_d;
      le_prev_q   <= le_prev_d;
    end
  end

  assign le_lvl    = pin_lvl[PIN_LE];
  assign sclk_rise = pin_lvl[PIN_SCLK] & ~sclk_prev_q;
  assign sclk_fall = ~pin_lvl[PIN_SCLK] & sclk_prev_q;
  assign le_rise   = le_lvl & ~le_prev_q;
  assign shift_en  = sclk_rise & ~le_lvl;

  logic [WORD_W-1:0] sreg;

  sps_shift #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .shift_en_i (shift_en),
    .bit_i      (pin_lvl[PIN_SDAT]),
    .out_en_i   (sclk_fall),
    .sreg_o     (sreg),
    .dout_o     (ser_dout_o)
  );

  sps_latch_bank #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (le_rise),
    .word_i (sreg),
    .cfg_o  (cfg_o),
    .upd_o  (cfg_upd_o)
  );
endmodule

// File: rtl/sps_prog_port_chk.sv
module sps_prog_port_chk #(
  parameter int unsigned WORD_W = 21,
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned PAY_W     = WORD_W - SEL_W,
  localparam int unsigned NUM_LATCH = 1 << SEL_W
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            sclk_fall,
  input logic                            le_lvl,
  input logic [WORD_W-1:0]               sreg,
  input logic                            dout,
  input logic [NUM_LATCH-1:0][PAY_W-1:0] cfg,
  input logic [NUM_LATCH-1:0]            upd
);
  AST_UPD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd)); // R5

  AST_UPD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd != '0) |=> (upd == '0)); // R5

  AST_SHIFT_FROZEN_LE: assert property (@(posedge clk) disable iff (!rst_n)
    le_lvl |=> $stable(sreg)); // R6

  AST_DOUT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(dout)); // R7

  generate
    for (genvar k = 0; k < NUM_LATCH; k++) begin : g_chk
      AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd[k] |-> $stable(cfg[k])); // R8

      AST_CFG_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        upd[k] |-> (cfg[k] == $past(sreg[WORD_W-1:SEL_W]))); // R4
    end
  endgenerate
endmodule

bind sps_prog_port sps_prog_port_chk #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sclk_fall (sclk_fall),
  .le_lvl    (le_lvl),
  .sreg      (sreg),
  .dout      (ser_dout_o),
  .cfg       (cfg_o),
  .upd       (cfg_upd_o)
);

// File: tb/tb_sps_prog_port.sv
module tb_sps_prog_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic sclk, sdat, sle;
  logic dout;
  logic [3:0][18:0] cfg;
  logic [3:0] upd;

  int n_tests = 0;
  int n_fail  = 0;
  int upd_cnt [4];
  logic [18:0] shadow [4];
  logic [20:0] model;
  logic exp_dout;

  sps_prog_port dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_clk_i  (sclk),
    .ser_dat_i  (sdat),
    .ser_le_i   (sle),
    .ser_dout_o (dout),
    .cfg_o      (cfg),
    .cfg_upd_o  (upd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 4; k++) if (upd[k]) upd_cnt[k]++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    sdat = b;
    wait_n(HALF);
    sclk = 1'b1;
    if (!sle) model = {model[19:0], b};
    wait_n(HALF);
    chk(dout == exp_dout, "R7 hold before fall", 32'(dout), 32'(exp_dout));
    sclk = 1'b0;
    wait_n(HALF);
    exp_dout = model[20];
    chk(dout == exp_dout, "R7 after fall", 32'(dout), 32'(exp_dout));
  endtask

  task automatic send_word(input logic [20:0] w);
    for (int i = 20; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic load_check();
    int pre [4];
    int a;
    for (int k = 0; k < 4; k++) pre[k] = upd_cnt[k];
    wait_n(HALF);
    sle = 1'b1;
    wait_n(2*HALF);
    sle = 1'b0;
    wait_n(HALF);
    a = int'(model[1:0]);
    shadow[a] = model[20:2];
    for (int k = 0; k < 4; k++) begin
      if (k == a) chk(cfg[k] == shadow[k], "R4 payload", 32'(cfg[k]), 32'(shadow[k]));
      else        chk(cfg[k] == shadow[k], "R3 unselected kept", 32'(cfg[k]), 32'(shadow[k]));
      chk(upd_cnt[k] == pre[k] + ((k == a) ? 1 : 0), "R5 strobe count",
          32'(upd_cnt[k]), 32'(pre[k] + ((k == a) ? 1 : 0)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [20:0] w;
    logic [18:0] old;
    seed = $urandom(32'd4711);
    rst_n = 1'b0; sclk = 1'b0; sdat = 1'b0; sle = 1'b0;
    model = '0; exp_dout = 1'b0;
    for (int k = 0; k < 4; k++) begin upd_cnt[k] = 0; shadow[k] = '0; end
    wait_n(5);
    chk(cfg == '0, "R1 cfg in reset", 32'(cfg[0]), 0);
    rst_n = 1'b1;
    wait_n(4);
    chk(cfg == '0, "R1 cfg after reset", 32'(cfg[1]), 0);
    chk(upd == '0, "R1 strobes", 32'(upd), 0);
    chk(dout == 1'b0, "R1 dout", 32'(dout), 0);

    // R2: MSB-first word order, one word per select value (R3)
    send_word(21'h155555 & ~21'h3); load_check();
    chk(cfg[0] == 19'h55555, "R2 msb first", 32'(cfg[0]), 32'h55555);
    send_word({19'h40001, 2'd1}); load_check();
    send_word({19'h7FFFF, 2'd2}); load_check();
    send_word({19'h00000, 2'd3}); load_check();
    send_word({19'h12345, 2'd3}); load_check();

    // R8: shift without load changes nothing
    send_word(21'h0ABCDE);
    for (int k = 0; k < 4; k++) chk(cfg[k] == shadow[k], "R8 no load", 32'(cfg[k]), 32'(shadow[k]));

    // R6: clocks while load-enable high are ignored
    send_word({19'h2A5A5, 2'd2}); load_check();
    old = cfg[2];
    sle = 1'b1;
    wait_n(2*HALF);
    for (int j = 0; j < 5; j++) shift_bit(1'b1);
    sle = 1'b0;
    wait_n(2*HALF);
    load_check();
    chk(cfg[2] == old, "R6 frozen shift", 32'(cfg[2]), 32'(old));

    // Random words
    for (int n = 0; n < 40; n++) begin
      w = 21'($urandom);
      send_word(w);
      load_check();
    end

    // R1: mid-run reset clears everything
    rst_n = 1'b0;
    wait_n(3);
    chk(cfg == '0, "R1 mid-run reset", 32'(cfg[2]), 0);
    rst_n = 1'b1;
    wait_n(4);
    chk(dout == 1'b0, "R1 dout after reset", 32'(dout), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule